// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a load-store processor whose procedure calls shift a register window instead of spilling registers to the stack. At any moment software addresses 32 architectural registers with a 5-bit number. Registers 1 to 7 are shared by every window. Register 0 is a constant zero. Registers 8 to 31 come from a circular physical array that holds `NWIN` windows of sixteen private registers each. A window owns its incoming group (8–15) and its local group (16–23). Its outgoing group (24–31) is physically the incoming group of the window one step below it, taken modulo `NWIN`.

A save request moves the window pointer down one step, so the caller's outgoing registers become the callee's incoming registers. A restore request moves it up one step. Both requests carry an add. In the same cycle, the read ports still show the old window, and a write issued in that cycle lands in the new window. A per-window invalid mask comes in as an input. A save or restore whose target window is marked raises a trap output instead of moving. Spilling windows to memory, the trap handler and the ALU are outside this block.

Top module: `regwin_file`

## Requirements
- R1: After reset every architectural register reads zero and the window pointer is at window `CWP_RESET` (default 0).
- R2: Architectural register 0 reads zero on both read ports, and a write to it has no effect.
- R3: Registers 1–7 name the same storage in every window, so a value written in one window reads back unchanged in all others.
- R4: In window w, registers 8–15 (incoming) and 16–23 (local) are private to w. Registers 24–31 (outgoing) are the same storage as registers 8–15 of window (w−1) mod NWIN.
- R5: An accepted save moves the pointer from w to (w−1) mod NWIN, and an accepted restore moves it to (w+1) mod NWIN; either takes effect at the clock edge.
- R6: The pointer wraps: a save from window 0 reaches window NWIN−1, and a restore from window NWIN−1 reaches window 0.
- R7: A save whose target window (w−1) mod NWIN has its bit set in `win_invalid` (bit i marks window i) raises `win_overflow` in that cycle. The pointer does not move, the write of that cycle is dropped, and set bits for other windows raise no trap.
- R8: A restore whose target window (w+1) mod NWIN has its `win_invalid` bit set raises `win_underflow` in that cycle, leaves the pointer unchanged and drops the write of that cycle.
- R9: During an accepted save or restore the read ports show the old window, and a write in that cycle goes to the register of the new window.
- R10: Reads are combinational from the current mapping. A write without save or restore uses the current mapping and is visible after the clock edge.
- R11: A save and a restore requested together do nothing: the pointer stays, neither trap is raised, and the write uses the current mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_addr | input | 5 | Architectural number, read port 0 |
| rd0_data | output | DATA_W | Read data, port 0 |
| rd1_addr | input | 5 | Architectural number, read port 1 |
| rd1_data | output | DATA_W | Read data, port 1 |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural destination number |
| wr_data | input | DATA_W | Write data |
| save_req | input | 1 | Move window toward the callee |
| restore_req | input | 1 | Move window back toward the caller |
| win_invalid | input | NWIN | Window-invalid mask, bit i marks window i |
| win_overflow | output | 1 | Save blocked by the mask |
| win_underflow | output | 1 | Restore blocked by the mask |

## Verification
The bench walks the pointer around the whole ring in both directions and writes a distinct value into every register of every window. This catches an off-by-one in the outgoing-group window, which would make a callee see the wrong caller's arguments, and a broken wrap, which would step into a window that does not exist. Traps are provoked with only the target bit of the mask set, and again with every bit except the target set. The first case would expose a design that moves anyway or lets the write through. The second would expose one that tests the wrong window's bit. Save-with-write checks that the reads show the old window and the write lands in the new one. Mapping both through the same window would corrupt the caller's registers.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   // registers per group (globals, ins, locals, outs)
   localparam int GRP_SIZE = 8;
   localparam int ARCH_AW  = 5;

   typedef enum logic [1:0] {
      MV_HOLD    = 2'd0,
      MV_SAVE    = 2'd1,
      MV_RESTORE = 2'd2
   } win_move_e;

   // step one window down the ring
   function automatic int win_dec(input int w, input int n);
      return (w == 0) ? n - 1 : w - 1;
   endfunction

   // step one window up the ring
   function automatic int win_inc(input int w, input int n);
      return (w >= n - 1) ? 0 : w + 1;
   endfunction

endpackage

// File: rtl/regwin_ptr.sv
module regwin_ptr
   import regwin_pkg::*;
#(
   parameter int NWIN      = 7,
   parameter int CWP_W     = 3,
   parameter int CWP_RESET = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save_req,
   input  logic             restore_req,
   input  logic [NWIN-1:0]  win_invalid,
   output logic [CWP_W-1:0] cwp,
   output logic [CWP_W-1:0] cwp_below,
   output logic [CWP_W-1:0] cwp_post,
   output logic [CWP_W-1:0] post_below,
   output logic             trap_ovf,
   output logic             trap_unf
);

   logic [CWP_W-1:0] cwp_above;
   logic             only_save;
   logic             only_restore;
   win_move_e        move;

   always_comb begin
      cwp_below    = CWP_W'(win_dec(int'(cwp), NWIN));
      cwp_above    = CWP_W'(win_inc(int'(cwp), NWIN));
      only_save    = save_req & ~restore_req;
      only_restore = restore_req & ~save_req;
      trap_ovf     = only_save & win_invalid[cwp_below];
      trap_unf     = only_restore & win_invalid[cwp_above];
      if (only_save && !trap_ovf)
         move = MV_SAVE;
      else if (only_restore && !trap_unf)
         move = MV_RESTORE;
      else
         move = MV_HOLD;
      unique case (move)
         MV_SAVE:    cwp_post = cwp_below;
         MV_RESTORE: cwp_post = cwp_above;
         default:    cwp_post = cwp;
      endcase
      post_below = CWP_W'(win_dec(int'(cwp_post), NWIN));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cwp <= CWP_W'(CWP_RESET);
      else
         cwp <= cwp_post;
   end

   AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cwp) < NWIN) else $error("pointer outside ring"); // R6
   AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ovf |=> cwp == $past(cwp)) else $error("moved on overflow"); // R7
   AST_UNF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_unf |=> cwp == $past(cwp)) else $error("moved on underflow"); // R8
   AST_TRAPS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_ovf && trap_unf)) else $error("both traps"); // R11
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && restore_req) |=> $stable(cwp)) else $error("moved on conflict"); // R11
   AST_SAVE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (only_save && !trap_ovf) |=> cwp != $past(cwp)) else $error("save did not move"); // R5
   AST_RESTORE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (only_restore && !trap_unf) |=> cwp != $past(cwp)) else $error("restore did not move"); // R5

endmodule

// File: rtl/regwin_map.sv
module regwin_map
   import regwin_pkg::*;
#(
   parameter int CWP_W   = 3,
   parameter int PHYS_AW = 7
) (
   input  logic [ARCH_AW-1:0] arch,
   input  logic [CWP_W-1:0]   win_own,
   input  logic [CWP_W-1:0]   win_out,
   output logic [PHYS_AW-1:0] phys
);

   logic [CWP_W-1:0] win_sel;
   logic [3:0]       slot;

   // layout: globals at 0..7, then 16 slots per window (ins then locals)
   always_comb begin
      win_sel = win_own;
      slot    = {1'b0, arch[2:0]};
      unique case (arch[4:3])
         2'd1: begin win_sel = win_own; slot = {1'b0, arch[2:0]}; end
         2'd2: begin win_sel = win_own; slot = {1'b1, arch[2:0]}; end
         2'd3: begin win_sel = win_out; slot = {1'b0, arch[2:0]}; end
         default: begin win_sel = win_own; slot = {1'b0, arch[2:0]}; end
      endcase
      if (arch[4:3] == 2'd0)
         phys = PHYS_AW'(arch[2:0]);
      else
         phys = PHYS_AW'({win_sel, slot}) + PHYS_AW'(GRP_SIZE);
   end

endmodule

// File: rtl/regwin_array.sv
module regwin_array #(
   parameter int DATA_W  = 32,
   parameter int PHYS_N  = 120,
   parameter int PHYS_AW = 7,
   parameter int NRD     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [PHYS_AW-1:0] waddr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [PHYS_AW-1:0] raddr [NRD],
   output logic [DATA_W-1:0]  rdata [NRD]
);

   logic [DATA_W-1:0] cells [PHYS_N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PHYS_N; i++)
            cells[i] <= '0;
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = cells[raddr[g]];
   end

   AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> waddr != '0) else $error("write to constant zero cell"); // R2

endmodule

// File: rtl/regwin_file.sv
module regwin_file
   import regwin_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NWIN      = 7,
   parameter int CWP_RESET = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        rd0_addr,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [4:0]        rd1_addr,
   output logic [DATA_W-1:0] rd1_data,
   input  logic              wr_en,
   input  logic [4:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              save_req,
   input  logic              restore_req,
   input  logic [NWIN-1:0]   win_invalid,
   output logic              win_overflow,
   output logic              win_underflow
);

   localparam int NRD     = 2;
   localparam int PHYS_N  = GRP_SIZE + NWIN * 2 * GRP_SIZE;
   localparam int PHYS_AW = $clog2(PHYS_N);
   localparam int CWP_W   = (NWIN > 1) ? $clog2(NWIN) : 1;

   if (NWIN < 2 || NWIN > 64) begin : g_bad_nwin
      $error("NWIN must lie in 2..64");
   end
   if (CWP_RESET < 0 || CWP_RESET >= NWIN) begin : g_bad_reset
      $error("CWP_RESET must name an existing window");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [CWP_W-1:0]   cwp, cwp_below, cwp_post, post_below;
   logic               trap_ovf, trap_unf;
   logic [4:0]         rd_arch [NRD];
   logic [PHYS_AW-1:0] rd_phys [NRD];
   logic [DATA_W-1:0]  rd_raw  [NRD];
   logic [PHYS_AW-1:0] wr_phys;
   logic               arr_we;

   regwin_ptr #(
      .NWIN(NWIN), .CWP_W(CWP_W), .CWP_RESET(CWP_RESET)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .save_req(save_req), .restore_req(restore_req),
      .win_invalid(win_invalid),
      .cwp(cwp), .cwp_below(cwp_below),
      .cwp_post(cwp_post), .post_below(post_below),
      .trap_ovf(trap_ovf), .trap_unf(trap_unf)
   );

   assign rd_arch[0] = rd0_addr;
   assign rd_arch[1] = rd1_addr;

   // reads see the window in force before this edge
   for (genvar g = 0; g < NRD; g++) begin : g_rmap
      regwin_map #(.CWP_W(CWP_W), .PHYS_AW(PHYS_AW)) u_map (
         .arch(rd_arch[g]), .win_own(cwp), .win_out(cwp_below),
         .phys(rd_phys[g])
      );
   end

   // the write lands in the window in force after this edge
   regwin_map #(.CWP_W(CWP_W), .PHYS_AW(PHYS_AW)) u_wmap (
      .arch(wr_addr), .win_own(cwp_post), .win_out(post_below),
      .phys(wr_phys)
   );

   assign arr_we = wr_en && (wr_addr != 5'd0) && !trap_ovf && !trap_unf;

   regwin_array #(
      .DATA_W(DATA_W), .PHYS_N(PHYS_N), .PHYS_AW(PHYS_AW), .NRD(NRD)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .we(arr_we), .waddr(wr_phys), .wdata(wr_data),
      .raddr(rd_phys), .rdata(rd_raw)
   );

   assign rd0_data      = (rd0_addr == 5'd0) ? '0 : rd_raw[0];
   assign rd1_data      = (rd1_addr == 5'd0) ? '0 : rd_raw[1];
   assign win_overflow  = trap_ovf;
   assign win_underflow = trap_unf;

   AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (win_overflow || win_underflow) |-> !arr_we) else $error("write on trap"); // R7
   AST_ZERO_READ0: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_addr == 5'd0 |-> rd0_data == '0) else $error("r0 nonzero port0"); // R2
   AST_ZERO_READ1: assert property (@(posedge clk) disable iff (!rst_n)
      rd1_addr == 5'd0 |-> rd1_data == '0) else $error("r0 nonzero port1"); // R2
   AST_OVF_NEEDS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      win_overflow |-> save_req && !restore_req) else $error("stray overflow"); // R7

endmodule

// File: tb/regwin_file_test.sv
module regwin_file_test;

   localparam int NW = 7;
   localparam int NP = 8 + NW * 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
   logic [31:0] rd0_data, rd1_data, wr_data = '0;
   logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
   logic [NW-1:0] win_invalid = '0;
   logic        win_overflow, win_underflow;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] model [NP];
   int mcwp = 0;

   always #10 clk = ~clk;

   regwin_file #(.DATA_W(32), .NWIN(NW), .CWP_RESET(0)) uut (
      .clk(clk), .rst_n(rst_n),
      .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_addr(rd1_addr), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .save_req(save_req), .restore_req(restore_req),
      .win_invalid(win_invalid),
      .win_overflow(win_overflow), .win_underflow(win_underflow)
   );

   // storage slot of architectural register a in window w, from R3/R4
   function automatic int slot_of(input int a, input int w);
      if (a < 8)  return a;
      if (a < 16) return 8 + w * 16 + (a - 8);
      if (a < 24) return 8 + w * 16 + 8 + (a - 16);
      return 8 + ((w + NW - 1) % NW) * 16 + (a - 24);
   endfunction

   function automatic logic [31:0] expect_rd(input int a, input int w);
      return (a == 0) ? 32'd0 : model[slot_of(a, w)];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      @(negedge clk);
      for (int a = 0; a < 32; a += 2) begin
         rd0_addr = 5'(a);
         rd1_addr = 5'(a + 1);
         #1;
         check($sformatf("%s %s r%0d", tag, (a == 0) ? "R2" : (a < 8) ? "R3" : "R4", a),
               rd0_data, expect_rd(a, mcwp));
         check($sformatf("%s %s r%0d", tag, (a < 8) ? "R3" : "R4", a + 1),
               rd1_data, expect_rd(a + 1, mcwp));
      end
   endtask

   // one cycle: optional save/restore plus optional write
   task automatic op(input bit sv, input bit rs, input bit we, input int wa,
                     input logic [31:0] wd, input logic [NW-1:0] wim, input string tag);
      int below, above, post;
      bit e_ovf, e_unf;
      below = (mcwp + NW - 1) % NW;
      above = (mcwp + 1) % NW;
      e_ovf = sv && !rs && wim[below];
      e_unf = rs && !sv && wim[above];
      post  = mcwp;
      if (sv && !rs && !e_ovf) post = below;
      if (rs && !sv && !e_unf) post = above;
      @(negedge clk);
      save_req    = sv;
      restore_req = rs;
      wr_en       = we;
      wr_addr     = 5'(wa);
      wr_data     = wd;
      win_invalid = wim;
      rd0_addr    = 5'd24;
      rd1_addr    = 5'd9;
      #2;
      check({tag, " R7 overflow"}, 32'(win_overflow), 32'(e_ovf));
      check({tag, " R8 underflow"}, 32'(win_underflow), 32'(e_unf));
      check({tag, " R9 old-window read r24"}, rd0_data, expect_rd(24, mcwp));
      check({tag, " R9 old-window read r9"}, rd1_data, expect_rd(9, mcwp));
      @(posedge clk);
      #1;
      if (we && wa != 0 && !e_ovf && !e_unf) model[slot_of(wa, post)] = wd;
      mcwp = post;
      save_req = 1'b0; restore_req = 1'b0; wr_en = 1'b0; win_invalid = '0;
   endtask

   initial begin
      for (int i = 0; i < NP; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");

      // R2: write to r0 is discarded
      op(0, 0, 1, 0, 32'hDEAD_BEEF, '0, "R2");
      check_all("R2 after r0 write");

      // R10: fill window 0 with plain writes
      for (int r = 1; r < 32; r++)
         op(0, 0, 1, r, 32'h1000_0000 + 32'(r), '0, "R10");
      check_all("R10 window0");

      // R5/R6/R9: full ring of saves, each with a write into the new window
      for (int s = 0; s < NW; s++) begin
         op(1, 0, 1, 16, 32'h2000_0000 + 32'(s), '0, (s == 0) ? "R6 save wrap" : "R5 save");
         check_all((s == 0) ? "R6 save wrap" : "R5 save");
         for (int r = 8; r < 32; r++)
            op(0, 0, 1, r, 32'h3000_0000 + 32'(s * 256 + r), '0, "R10");
         check_all("R4 filled window");
      end

      // R7: target window masked
      op(1, 0, 1, 17, 32'hBAD0_0001, 7'(1 << ((mcwp + NW - 1) % NW)), "R7 masked");
      check_all("R7 after overflow");
      // R7: every other window masked, save proceeds
      op(1, 0, 1, 17, 32'h4000_0001, ~7'(1 << ((mcwp + NW - 1) % NW)), "R7 other bits");
      check_all("R7 unmasked target");

      // R8: restore target masked
      op(0, 1, 1, 18, 32'hBAD0_0002, 7'(1 << ((mcwp + 1) % NW)), "R8 masked");
      check_all("R8 after underflow");

      // R5/R6: restores around the ring, each with a write into the new window
      for (int s = 0; s < NW + 1; s++) begin
         op(0, 1, 1, 24 + (s % 8), 32'h5000_0000 + 32'(s), '0,
            (mcwp == NW - 1) ? "R6 restore wrap" : "R5 restore");
         check_all("R5 restore");
      end

      // R11: both requests together
      op(1, 1, 1, 20, 32'h6000_0000, '1, "R11 both");
      check_all("R11 no move");

      // R3: global written in a far window visible everywhere
      op(1, 0, 1, 5, 32'h7000_0005, '0, "R3");
      op(1, 0, 0, 0, 32'h0, '0, "R3");
      check_all("R3 globals");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule